// File: doc/BRIEF.md
# Peripheral Reset Pulse Controller

This block drives 64 reset lines into the peripherals and cores of a chip and is programmed over a plain 32-bit register port. The port has an address, a write strobe, write data and read data. Two control words start resets, and two status words report which lines are held in reset. Most lines are self-releasing. A 1 written to such a line asserts it, and a counter then releases the line after a fixed number of delay-clock enable pulses. A 0 written to such a line does nothing.

Two lines, 12 and 56, are level-held. Every write to the control word that contains one of them loads that bit from the written value. Software must therefore write the current state of a held line back whenever it starts a pulse on another line in the same word. Line 0 is the reset of the main processor core and behaves as an ordinary self-releasing line. The register port has no handshake. A write takes effect on the clock edge on which its strobe is sampled. Read data is combinational from the address.

Top module: `prst_ctrl`

## Requirements
- R1: After the unit's own reset, all 64 outputs are released (low), and both status words read 0xFFFFFFFF.
- R2: Line n belongs to control word n/32 at bit n%32. Word 0 is at byte offset 0x100 and word 1 is at 0x104. A write there acts on the clock edge where the strobe is sampled, and the output changes at that edge.
- R3: Status word 0 at 0x150 and status word 1 at 0x154 show, at bit n%32, a 0 while line n is asserted and a 1 while it is released.
- R4: After a 1 is written to an ordinary line, the line stays high until the edge that samples the PULSE_TICKS-th `dly_tick` after the write. It falls at that edge.
- R5: Writing 0 to an ordinary line changes nothing. An idle line stays idle, and a running pulse keeps its remaining count.
- R6: Writing 1 to an ordinary line whose pulse is running reloads the full count. If a `dly_tick` arrives in the same cycle as the write, the reload wins.
- R7: Lines 12 and 56 take the written bit on every write to their control word and ignore `dly_tick`. A write of 0 releases them.
- R8: Control words read as zero. Any address other than the four words reads zero, and writes to such an address change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset of the unit |
| dly_tick | input | 1 | One-cycle enable from the delay clock domain that paces pulse timers |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rst_out | output | 64 | Reset lines, high means asserted |

## Verification
A control write and a delay tick can land in the same cycle on a line whose pulse is running. The bench creates this overlap by raising `dly_tick` together with a restarting write. It then counts the ticks until release, and the count must be the full length with no tick lost. A write of held-line bits and a pulse start on another line also fall on a single edge, because both share one control word. The bench checks that each line takes its own rule at that edge by comparing all 64 outputs with an arithmetic model after every cycle.

// File: rtl/prst_pkg.sv
package prst_pkg;
  localparam int WORD_W = 32;

  // True when a line index is one of the two level-held lines
  function automatic bit is_held(input int idx, input int held_a, input int held_b);
    return (idx == held_a) || (idx == held_b);
  endfunction
endpackage

// File: rtl/prst_decode.sv
module prst_decode #(
  parameter int ADDR_W    = 12,
  parameter int WORDS     = 2,
  parameter int CTRL_BASE = 'h100,
  parameter int STAT_BASE = 'h150
) (
  input  logic [ADDR_W-1:0]                   addr,
  input  logic                                we,
  input  logic [WORDS*prst_pkg::WORD_W-1:0]   status_in,
  output logic [WORDS-1:0]                    ctrl_wr,
  output logic [prst_pkg::WORD_W-1:0]         rdata
);
  localparam int W = prst_pkg::WORD_W;

  always_comb begin
    ctrl_wr = '0;
    rdata   = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (addr == ADDR_W'(CTRL_BASE + 4 * w)) ctrl_wr[w] = we;
      if (addr == ADDR_W'(STAT_BASE + 4 * w)) rdata = ~status_in[w*W +: W];
    end
  end
endmodule

// File: rtl/prst_line.sv
module prst_line #(
  parameter bit HELD        = 1'b0,
  parameter int PULSE_TICKS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wr,
  input  logic wbit,
  output logic active
);
  localparam int CNT_W = $clog2(PULSE_TICKS + 1);

  generate
    if (HELD) begin : g_level
      logic lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  lvl_q <= 1'b0;
        else if (wr) lvl_q <= wbit;
      end
      assign active = lvl_q;
    end else begin : g_pulse
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (wr && wbit)             cnt_q <= CNT_W'(PULSE_TICKS);
        else if (tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end
      assign active = (cnt_q != '0);
    end
  endgenerate
endmodule

// File: rtl/prst_ctrl.sv
module prst_ctrl #(
  parameter int ADDR_W      = 12,
  parameter int CTRL_BASE   = 'h100,
  parameter int STAT_BASE   = 'h150,
  parameter int HELD_A      = 12,
  parameter int HELD_B      = 56,
  parameter int PULSE_TICKS = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dly_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [63:0]       rst_out
);
  localparam int W     = prst_pkg::WORD_W;
  localparam int WORDS = 2;
  localparam int LINES = WORDS * W;

  logic [WORDS-1:0] ctrl_wr;

  prst_decode #(
    .ADDR_W(ADDR_W), .WORDS(WORDS), .CTRL_BASE(CTRL_BASE), .STAT_BASE(STAT_BASE)
  ) u_dec (
    .addr(bus_addr), .we(bus_we), .status_in(rst_out),
    .ctrl_wr(ctrl_wr), .rdata(bus_rdata)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    prst_line #(
      .HELD(prst_pkg::is_held(i, HELD_A, HELD_B)), .PULSE_TICKS(PULSE_TICKS)
    ) u_line (
      .clk(clk), .rst_n(rst_n), .tick(dly_tick),
      .wr(ctrl_wr[i / W]), .wbit(bus_wdata[i % W]), .active(rst_out[i])
    );
  end
endmodule

// File: rtl/prst_ctrl_chk.sv
module prst_ctrl_chk #(
  parameter int ADDR_W    = 12,
  parameter int CTRL_BASE = 'h100,
  parameter int STAT_BASE = 'h150
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dly_tick,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [63:0]       rst_out
);
  localparam logic [ADDR_W-1:0] C0 = ADDR_W'(CTRL_BASE);
  localparam logic [ADDR_W-1:0] C1 = ADDR_W'(CTRL_BASE + 4);
  localparam logic [ADDR_W-1:0] S0 = ADDR_W'(STAT_BASE);

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> rst_out == '0);

  p_status_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == S0 |-> bus_rdata == ~rst_out[31:0]);

  p_ctrl_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == C0 || bus_addr == C1) |-> bus_rdata == '0);

  p_start_asserts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == C0 && bus_wdata[0]) |=> rst_out[0]);

  p_release_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out[0]) |-> $past(dly_tick));

  p_held_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == C0) |=> rst_out[12] == $past(bus_wdata[12]));

  p_held_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == C1) |=> rst_out[56] == $past(rst_out[56]));
endmodule

bind prst_ctrl prst_ctrl_chk #(
  .ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE), .STAT_BASE(STAT_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dly_tick(dly_tick), .bus_addr(bus_addr),
  .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_out(rst_out)
);

// File: tb/prst_ctrl_tb.sv
module prst_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P          = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dly_tick = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] rst_out;

  int n_run = 0;
  int n_fail = 0;
  int cnt_m [64];
  bit held_m [64];

  prst_ctrl #(.PULSE_TICKS(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .dly_tick(dly_tick), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_out(rst_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [63:0] model_out();
    logic [63:0] v;
    for (int i = 0; i < 64; i++)
      v[i] = (i == 12 || i == 56) ? held_m[i] : (cnt_m[i] != 0);
    return v;
  endfunction

  task automatic chk_out(input string tag);
    logic [63:0] e;
    e = model_out();
    n_run++;
    if (rst_out !== e) begin
      n_fail++;
      $display("FAIL %s rst_out=%h exp=%h", tag, rst_out, e);
    end
  endtask

  task automatic chk_read(input logic [11:0] a, input logic [31:0] e, input string tag);
    bus_addr = a;
    #1;
    n_run++;
    if (bus_rdata !== e) begin
      n_fail++;
      $display("FAIL %s addr=%h rdata=%h exp=%h", tag, a, bus_rdata, e);
    end
  endtask

  // One clock: drive after negedge, update model at posedge, check at next negedge
  task automatic step(input bit we, input logic [11:0] a, input logic [31:0] d,
                      input bit tk, input string tag);
    bus_we = we; bus_addr = a; bus_wdata = d; dly_tick = tk;
    @(posedge clk);
    for (int i = 0; i < 64; i++) begin
      bit hit;
      hit = we && (a == 12'(32'h100 + 4 * (i / 32)));
      if (i == 12 || i == 56) begin
        if (hit) held_m[i] = d[i % 32];
      end else if (hit && d[i % 32]) cnt_m[i] = P;
      else if (tk && cnt_m[i] > 0) cnt_m[i]--;
    end
    @(negedge clk);
    bus_we = 1'b0; dly_tick = 1'b0;
    chk_out(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin cnt_m[i] = 0; held_m[i] = 0; end
    repeat (3) @(negedge clk);
    chk_out("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_out("R1");
    chk_read(12'h150, 32'hFFFF_FFFF, "R1");
    chk_read(12'h154, 32'hFFFF_FFFF, "R1");

    // Sweep every line: ordinary lines pulse, held lines latch
    for (int n = 0; n < 64; n++) begin
      logic [11:0] ca, sa;
      ca = 12'(32'h100 + 4 * (n / 32));
      sa = 12'(32'h150 + 4 * (n / 32));
      step(1'b1, ca, 32'h1 << (n % 32), 1'b0, "R2");
      chk_read(sa, ~(32'h1 << (n % 32)), "R3");
      for (int t = 0; t < P + 1; t++) step(1'b0, 12'h0, '0, 1'b1, (n == 12 || n == 56) ? "R7" : "R4");
      if (n == 12 || n == 56) step(1'b1, ca, '0, 1'b0, "R7");
      chk_read(sa, 32'hFFFF_FFFF, "R3");
    end

    // R5: a zero write neither stops a running pulse nor starts one
    step(1'b1, 12'h100, 32'h8, 1'b1, "R5");
    step(1'b0, 12'h0, '0, 1'b1, "R5");
    step(1'b1, 12'h100, 32'h0, 1'b0, "R5");
    step(1'b1, 12'h104, 32'h0, 1'b1, "R5");
    for (int t = 0; t < P; t++) step(1'b0, 12'h0, '0, 1'b1, "R5");

    // R6: restart with a tick in the same cycle reloads the full count
    step(1'b1, 12'h104, 32'h100, 1'b0, "R6");
    step(1'b0, 12'h0, '0, 1'b1, "R6");
    step(1'b0, 12'h0, '0, 1'b1, "R6");
    step(1'b1, 12'h104, 32'h100, 1'b1, "R6");
    for (int t = 0; t < P; t++) step(1'b0, 12'h0, '0, 1'b1, "R6");

    // R7: a write without the held bit drops it while starting another pulse
    step(1'b1, 12'h100, 32'h1000, 1'b0, "R7");
    step(1'b1, 12'h104, 32'h0100_0000, 1'b0, "R7");
    step(1'b1, 12'h100, 32'h20, 1'b0, "R7");
    step(1'b1, 12'h104, 32'h0100_0000, 1'b1, "R7");

    // R8: control words read zero, unmapped addresses do nothing
    chk_read(12'h100, '0, "R8");
    chk_read(12'h104, '0, "R8");
    step(1'b1, 12'h108, 32'hFFFF_FFFF, 1'b0, "R8");
    step(1'b1, 12'h150, 32'hFFFF_FFFF, 1'b0, "R8");
    step(1'b1, 12'h0FC, 32'hFFFF_FFFF, 1'b0, "R8");
    chk_read(12'h108, '0, "R8");
    chk_read(12'h000, '0, "R8");
    step(1'b1, 12'h104, 32'h0, 1'b0, "R7");
    for (int t = 0; t < P; t++) step(1'b0, 12'h0, '0, 1'b1, "R4");
    chk_read(12'h154, 32'hFFFF_FFFF, "R3");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule